// File: doc/BRIEF.md
# Offset-Binary Partitioned LUT Reader

This block turns one wide bit-slice address into a signed partial coefficient sum, for use inside a distributed-arithmetic FIR datapath. The address is split into fixed-width clusters and each cluster indexes its own memory partition. Each partition covers one group of taps. Offset binary coding halves each partition's depth: the cluster's top bit is XOR-ed into the lower bits to form the partition address, and the same top bit then negates the word that is read. Partitions that belong to switched-off tap groups add zero. The per-partition values are summed in a registered binary adder tree, so one address can be accepted every cycle.

The partition contents are loaded beforehand through a simple write port that takes a partition index, a word address and a data word. With the default sizes there are eight partitions of 128 words of 22 bits each, a 64-bit address, and a 25-bit signed result that is valid four clock edges after the address is taken.

Top module: `obc_lut_reader`

## Requirements
- R1: Partition i is addressed by cluster i, which is `in_addr[8i+7:8i]`; partition 0 takes bits 7:0 and partition 7 takes bits 63:56.
- R2: A cluster's partition address is its low 7 bits XOR-ed bitwise with its bit 7, so cluster 0x00 and cluster 0xFF both read word 0, and cluster 0x80 reads word 0x7F.
- R3: When bit 7 of a cluster is 1, the two's-complement 22-bit word read from that partition goes into the sum negated. When bit 7 is 0 the word goes in unchanged.
- R4: When `part_en[i]` is 0 at the cycle the address is taken, partition i adds exactly zero. A mask of all zeros yields a result of 0.
- R5: `out_sum` is the exact signed sum of the enabled partition terms for every stored word in the range -(2^21-1) to 2^21-1, including the case where all eight terms are at the same extreme.
- R6: Each cycle with `in_valid` high gives exactly one `out_valid` pulse four rising edges later, counting the edge that samples the address. Addresses on consecutive cycles give results on consecutive cycles.
- R7: While `out_valid` is low, `out_sum` keeps its last value.
- R8: A synchronous active-high `rst` clears `out_valid` and `out_sum` to 0.
- R9: With `wr_en` high, `wr_data` is stored at word `wr_addr` of partition `wr_part`. A read taken on any later cycle returns it, and no other partition or word changes.
- R10: A write must not target a partition that is enabled for a read on the same cycle. A write to a disabled partition during a stream of reads leaves those reads unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Address strobe |
| in_addr | input | 64 | Bit-slice address, eight 8-bit clusters |
| part_en | input | 8 | Tap-group enable mask, one bit per partition |
| wr_en | input | 1 | Partition write strobe |
| wr_part | input | 3 | Partition index for the write |
| wr_addr | input | 7 | Word address within the partition |
| wr_data | input | 22 | Two's-complement word to store |
| out_valid | output | 1 | Result strobe |
| out_sum | output | 25 | Signed partial coefficient sum |

## Verification
A single enabled partition with random addresses shows whether each cluster reaches its own partition. Pairs of clusters such as 0x00/0xFF and 0x05/0xFA separate a wrong fold from a wrong sign, because they read the same word with opposite signs. Fixed masks (none, all, low half, alternating) and random masks show zeroing faults. Extreme words in all partitions, long back-to-back random streams and streams with idle gaps test the width of the sum, the latency and the hold behaviour. A write to a disabled partition in the middle of a stream, followed by a read of it, tests write isolation and that the new word is seen.

// File: rtl/obc_pkg.sv
package obc_pkg;
  localparam int DEF_NUM_PART  = 8;
  localparam int DEF_CLUSTER_W = 8;
  localparam int DEF_WORD_W    = 22;

  function automatic int sum_width(input int word_w, input int num_part);
    return word_w + $clog2(num_part);
  endfunction

  function automatic int tree_levels(input int num_part);
    return $clog2(num_part);
  endfunction
endpackage

// File: rtl/obc_fold.sv
module obc_fold #(
  parameter int CLUSTER_W = 8
) (
  input  logic [CLUSTER_W-1:0] cluster,
  output logic [CLUSTER_W-2:0] word_addr,
  output logic                 negate
);
  assign negate    = cluster[CLUSTER_W-1];
  assign word_addr = cluster[CLUSTER_W-2:0] ^ {(CLUSTER_W-1){cluster[CLUSTER_W-1]}};
endmodule

// File: rtl/lut_bank.sv
module lut_bank #(
  parameter int AW     = 7,
  parameter int WORD_W = 22
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/obc_term.sv
module obc_term #(
  parameter int WORD_W = 22,
  parameter int SUM_W  = 25
) (
  input  logic [WORD_W-1:0]       word,
  input  logic                    negate,
  input  logic                    enable,
  output logic signed [SUM_W-1:0] term
);
  logic signed [SUM_W-1:0] ext;

  always_comb begin
    ext = {{(SUM_W-WORD_W){word[WORD_W-1]}}, word};
    if (!enable)     term = '0;
    else if (negate) term = -ext;
    else             term = ext;
  end
endmodule

// File: rtl/sum_tree.sv
module sum_tree #(
  parameter int N = 8,
  parameter int W = 25
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_vld,
  input  logic signed [W-1:0] terms [N],
  output logic                out_vld,
  output logic signed [W-1:0] sum
);
  localparam int LEVELS = $clog2(N);

  logic [LEVELS:0] vld;
  assign vld[0] = in_vld;

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int CNT = N >> l;
    logic signed [W-1:0] s [CNT];
    if (l == 0) begin : g_in
      always_comb begin
        for (int j = 0; j < CNT; j++) s[j] = terms[j];
      end
    end else begin : g_add
      always_ff @(posedge clk) begin
        if (rst) vld[l] <= 1'b0;
        else     vld[l] <= vld[l-1];
      end
      for (genvar j = 0; j < CNT; j++) begin : g_node
        always_ff @(posedge clk) begin
          if (rst)           s[j] <= '0;
          else if (vld[l-1]) s[j] <= g_lvl[l-1].s[2*j] + g_lvl[l-1].s[2*j+1];
        end
      end
    end
  end

  assign out_vld = vld[LEVELS];
  assign sum     = g_lvl[LEVELS].s[0];
endmodule

// File: rtl/obc_lut_reader.sv
module obc_lut_reader
  import obc_pkg::*;
#(
  parameter int NUM_PART  = DEF_NUM_PART,
  parameter int CLUSTER_W = DEF_CLUSTER_W,
  parameter int WORD_W    = DEF_WORD_W
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   in_valid,
  input  logic [NUM_PART*CLUSTER_W-1:0]          in_addr,
  input  logic [NUM_PART-1:0]                    part_en,
  input  logic                                   wr_en,
  input  logic [$clog2(NUM_PART)-1:0]            wr_part,
  input  logic [CLUSTER_W-2:0]                   wr_addr,
  input  logic [WORD_W-1:0]                      wr_data,
  output logic                                   out_valid,
  output logic [WORD_W+$clog2(NUM_PART)-1:0]     out_sum
);
  localparam int AW     = CLUSTER_W - 1;
  localparam int PIDX_W = $clog2(NUM_PART);
  localparam int SUM_W  = sum_width(WORD_W, NUM_PART);

  logic [NUM_PART-1:0]     s1_neg;
  logic [NUM_PART-1:0]     s1_en;
  logic                    s1_vld;
  logic signed [SUM_W-1:0] terms [NUM_PART];
  logic signed [SUM_W-1:0] tree_sum;

  for (genvar i = 0; i < NUM_PART; i++) begin : g_part
    logic [AW-1:0]     raddr;
    logic              neg;
    logic [WORD_W-1:0] rdata;
    logic              we;

    assign we = wr_en && (wr_part == PIDX_W'(i));

    obc_fold #(.CLUSTER_W(CLUSTER_W)) u_fold (
      .cluster   (in_addr[i*CLUSTER_W +: CLUSTER_W]),
      .word_addr (raddr),
      .negate    (neg)
    );

    lut_bank #(.AW(AW), .WORD_W(WORD_W)) u_bank (
      .clk   (clk),
      .we    (we),
      .waddr (wr_addr),
      .wdata (wr_data),
      .re    (in_valid && part_en[i]),
      .raddr (raddr),
      .rdata (rdata)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_neg[i] <= 1'b0;
        s1_en[i]  <= 1'b0;
      end else if (in_valid) begin
        s1_neg[i] <= neg;
        s1_en[i]  <= part_en[i];
      end
    end

    obc_term #(.WORD_W(WORD_W), .SUM_W(SUM_W)) u_term (
      .word   (rdata),
      .negate (s1_neg[i]),
      .enable (s1_en[i]),
      .term   (terms[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) s1_vld <= 1'b0;
    else     s1_vld <= in_valid;
  end

  sum_tree #(.N(NUM_PART), .W(SUM_W)) u_tree (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (s1_vld),
    .terms   (terms),
    .out_vld (out_valid),
    .sum     (tree_sum)
  );

  assign out_sum = tree_sum;
endmodule

// File: rtl/obc_lut_reader_chk.sv
module obc_lut_reader_chk #(
  parameter int NUM_PART  = 8,
  parameter int CLUSTER_W = 8,
  parameter int WORD_W    = 22
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               in_valid,
  input logic [NUM_PART-1:0]                part_en,
  input logic                               wr_en,
  input logic [$clog2(NUM_PART)-1:0]        wr_part,
  input logic                               out_valid,
  input logic [WORD_W+$clog2(NUM_PART)-1:0] out_sum
);
  localparam int LAT = $clog2(NUM_PART) + 1;

  logic [LAT-1:0] vsh;
  logic [LAT-1:0] zsh;
  logic           armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      vsh   <= '0;
      zsh   <= '0;
      armed <= 1'b0;
    end else begin
      vsh   <= {vsh[LAT-2:0], in_valid};
      zsh   <= {zsh[LAT-2:0], in_valid && (part_en == '0)};
      armed <= 1'b1;
    end
  end

  // R6
  latency_match_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == vsh[LAT-1]);

  // R4
  masked_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (vsh[LAT-1] && zsh[LAT-1]) |-> (out_sum == '0));

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !out_valid) |-> $stable(out_sum));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sum == '0));

  // R10
  no_collision_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && in_valid && part_en[wr_part]));
endmodule

bind obc_lut_reader obc_lut_reader_chk #(
  .NUM_PART(NUM_PART), .CLUSTER_W(CLUSTER_W), .WORD_W(WORD_W)
) u_chk (.*);

// File: tb/tb_obc_lut_reader.sv
module tb_obc_lut_reader;
  localparam int NP   = 8;
  localparam int DEP  = 128;
  localparam int LAT  = 4;
  localparam int MAXV = (1 << 21) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_addr = '0;
  logic [7:0]  part_en = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_part = '0;
  logic [6:0]  wr_addr = '0;
  logic [21:0] wr_data = '0;
  logic        out_valid;
  logic [24:0] out_sum;

  obc_lut_reader dut (.*);

  always #4 clk = ~clk;

  int     mm [NP][DEP];
  bit     q_vld[$];
  longint q_sum[$];
  longint last_exp = 0;
  int     vectors = 0;
  int     fails = 0;
  bit     done = 0;

  function automatic longint model_sum(input logic [63:0] a, input logic [7:0] en);
    longint s = 0;
    for (int i = 0; i < NP; i++) begin
      logic [7:0] c = a[8*i +: 8];
      int idx = int'(c[6:0] ^ {7{c[7]}});
      longint v = mm[i][idx];
      if (c[7]) v = -v;
      if (en[i]) s += v;
    end
    return s;
  endfunction

  task automatic step(input bit v, input logic [63:0] a, input logic [7:0] en,
                      input bit we, input int wp, input int wa, input int wd,
                      input string tag);
    @(negedge clk);
    in_valid = v; in_addr = a; part_en = en;
    wr_en = we; wr_part = 3'(wp); wr_addr = 7'(wa); wr_data = 22'(wd);
    q_vld.push_back(v);
    q_sum.push_back(v ? model_sum(a, en) : 0);
    if (we) mm[wp][wa] = wd;
    @(posedge clk);
    #2;
    if (q_vld.size() == LAT) begin
      bit     ev = q_vld.pop_front();
      longint es = q_sum.pop_front();
      longint got = $signed(out_sum);
      if (ev) last_exp = es;
      vectors++;
      if (out_valid !== ev || got != last_exp) begin
        fails++;
        $display("FAIL %s: out_valid=%0b out_sum=%0d expected out_valid=%0b out_sum=%0d",
                 tag, out_valid, got, ev, last_exp);
      end
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(0, '0, '0, 0, 0, 0, 0, tag);
  endtask

  function automatic int rnd_word();
    return int'($urandom_range(2 * MAXV)) - MAXV;
  endfunction

  function automatic logic [63:0] rnd_addr();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #2;
    vectors++;
    if (out_valid !== 1'b0 || out_sum !== '0) begin
      fails++;
      $display("FAIL R8: out_valid=%0b out_sum=%0d expected 0 0", out_valid, out_sum);
    end
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < LAT - 1; k++) begin
      q_vld.push_back(0);
      q_sum.push_back(0);
    end

    // R9: load every partition, output must stay idle
    for (int p = 0; p < NP; p++)
      for (int w = 0; w < DEP; w++)
        step(0, '0, '0, 1, p, w, rnd_word(), "R9");
    idle(LAT, "R7");

    // R1: one partition at a time
    for (int i = 0; i < NP; i++)
      for (int k = 0; k < 6; k++) step(1, rnd_addr(), 8'(1 << i), 0, 0, 0, 0, "R1");

    // R2: clusters 0x00 and 0xFF read the same word with opposite sign
    step(1, 64'h00FF_00FF_00FF_00FF, 8'hFF, 0, 0, 0, 0, "R2");
    step(1, 64'h0000_0000_0000_0000, 8'hFF, 0, 0, 0, 0, "R2");
    step(1, 64'h8080_8080_8080_8080, 8'hFF, 0, 0, 0, 0, "R2");
    step(1, 64'h7F7F_7F7F_7F7F_7F7F, 8'hFF, 0, 0, 0, 0, "R2");

    // R3: all clusters negated
    for (int k = 0; k < 10; k++) step(1, rnd_addr() | 64'h8080_8080_8080_8080, 8'hFF, 0, 0, 0, 0, "R3");

    // R4: fixed and random masks
    step(1, rnd_addr(), 8'h00, 0, 0, 0, 0, "R4");
    step(1, rnd_addr(), 8'hFF, 0, 0, 0, 0, "R4");
    step(1, rnd_addr(), 8'h0F, 0, 0, 0, 0, "R4");
    step(1, rnd_addr(), 8'hA5, 0, 0, 0, 0, "R4");
    step(1, rnd_addr(), 8'h00, 0, 0, 0, 0, "R4");
    for (int k = 0; k < 20; k++) step(1, rnd_addr(), 8'($urandom), 0, 0, 0, 0, "R4");

    // R5: extremes in word 5 of every partition
    idle(2, "R7");
    for (int p = 0; p < NP; p++) step(0, '0, '0, 1, p, 5, MAXV, "R9");
    step(1, 64'h0505_0505_0505_0505, 8'hFF, 0, 0, 0, 0, "R5");
    step(1, 64'hFAFA_FAFA_FAFA_FAFA, 8'hFF, 0, 0, 0, 0, "R5");
    for (int p = 0; p < NP; p++) step(0, '0, '0, 1, p, 5, -MAXV, "R9");
    step(1, 64'h0505_0505_0505_0505, 8'hFF, 0, 0, 0, 0, "R5");
    step(1, 64'hFAFA_FAFA_FAFA_FAFA, 8'hFF, 0, 0, 0, 0, "R5");

    // R6: back-to-back stream
    for (int k = 0; k < 300; k++) step(1, rnd_addr(), 8'($urandom), 0, 0, 0, 0, "R6");

    // R7: gaps between valid addresses
    for (int k = 0; k < 60; k++) begin
      step(1, rnd_addr(), 8'hFF, 0, 0, 0, 0, "R7");
      idle(int'($urandom_range(3)), "R7");
    end

    // R10: rewrite partition 7 while streaming reads with it disabled
    for (int k = 0; k < 40; k++)
      step(1, rnd_addr(), 8'h7F & 8'($urandom), 1, 7, k, rnd_word(), "R10");
    for (int k = 0; k < 40; k++) begin
      logic [63:0] a = rnd_addr();
      a[63:56] = 8'(k) | (($urandom & 1) != 0 ? 8'h80 : 8'h00);
      if (a[63]) a[62:56] = ~7'(k);
      step(1, a, 8'h80, 0, 0, 0, 0, "R9");
    end

    idle(LAT + 2, "R7");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule